// File: doc/BRIEF.md
# MIPS Subset Instruction Decoder

This block is the decode stage of a single-cycle processor that runs a small MIPS integer subset: add, sub, and, or, slt, addi, lw, sw, beq and j. It is purely combinational. It takes one 32-bit instruction word and the address that word was fetched from. In the same cycle it returns the split-out instruction fields, the datapath control bits, the 4-bit operation code for the ALU, the sign-extended immediate, and both candidate next-PC addresses: the branch target and the jump target.

Whether a branch is actually taken depends on register data, so that decision is made outside this block. The register file, ALU, memories and the PC register are also outside. Any opcode outside the subset drives every control bit to 0, so an unknown word writes nothing and moves no data. Every control bit that the instruction does not need is driven to 0 rather than left undefined.

Top module: `mips_subset_decoder`

## Requirements
- R1: The fields are taken from these bit positions of `instr`. Opcode is [31:26], rs is [25:21], rt is [20:16], rd is [15:11], shamt is [10:6] and funct is [5:0]. The immediate is [15:0] and the jump index is [25:0].
- R2: Opcode 6'b000000 (R-type) sets `dst_rd` and `rf_we` and drives `alu_class`=2'b10. All other control bits are 0.
- R3: Opcode 6'b100011 (lw) sets `opb_imm`, `wb_mem`, `rf_we` and `mrd_en` and drives `alu_class`=2'b00. All other control bits are 0.
- R4: Opcode 6'b101011 (sw) sets `opb_imm` and `mwr_en` and drives `alu_class`=2'b00. All other control bits are 0.
- R5: Opcode 6'b000100 (beq) sets `br_en` and drives `alu_class`=2'b01. All other control bits are 0.
- R6: Opcode 6'b001000 (addi) sets `opb_imm` and `rf_we` and drives `alu_class`=2'b00 with `dst_rd`=0. All other control bits are 0.
- R7: Opcode 6'b000010 (j) sets `jmp_en` only. `alu_class` is 2'b00 and all other control bits are 0.
- R8: Every other opcode drives all nine control outputs to 0.
- R9: When `alu_class` is 2'b00, `alu_func` is 4'b0010 (add). When it is 2'b01, `alu_func` is 4'b0110 (sub). In both cases funct has no effect.
- R10: When `alu_class` is 2'b10, funct selects `alu_func`. add 6'b100000 gives 4'b0010, sub 6'b100010 gives 4'b0110, and 6'b100100 gives 4'b0000, or 6'b100101 gives 4'b0001, and slt 6'b101010 gives 4'b0111. Every other funct gives 4'b0000.
- R11: `imm_ext` is the 16-bit immediate read as two's complement and widened to 32 bits. For example, 0xfffe gives 0xfffffffe and 0x03e8 gives 0x000003e8.
- R12: `pc_plus4` equals `pc`+4. `br_target` equals `pc_plus4` plus four times the sign-extended immediate, modulo 2^32. For example, pc 0x0040001c with offset 0xfff8 gives 0x00400000.
- R13: `jmp_target` is built from three parts. Its top 4 bits are `pc_plus4`[31:28], the next 26 bits are the jump index, and the two low bits are 00. For example, 0x08100009 at pc 0x00400038 gives 0x00400024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being decoded |
| pc | input | 32 | Address the instruction was fetched from |
| opcode | output | 6 | Primary opcode field |
| rs | output | 5 | First source register number |
| rt | output | 5 | Second source / immediate-form destination register |
| rd | output | 5 | R-type destination register |
| shamt | output | 5 | Shift amount field |
| funct | output | 6 | R-type function field |
| imm | output | 16 | Raw immediate field |
| jidx | output | 26 | Raw jump index field |
| dst_rd | output | 1 | Write destination comes from rd instead of rt |
| jmp_en | output | 1 | Next PC is the jump target |
| br_en | output | 1 | Instruction is a conditional branch |
| mrd_en | output | 1 | Data memory read |
| wb_mem | output | 1 | Register write-back value comes from memory |
| alu_class | output | 2 | Operation class passed to ALU control |
| mwr_en | output | 1 | Data memory write |
| opb_imm | output | 1 | ALU second operand is the extended immediate |
| rf_we | output | 1 | Register file write enable |
| alu_func | output | 4 | ALU operation code |
| imm_ext | output | 32 | Sign-extended immediate |
| pc_plus4 | output | 32 | Sequential next address |
| br_target | output | 32 | Branch destination address |
| jmp_target | output | 32 | Jump destination address |

## Verification
The bench sweeps all 64 opcodes while the lower bits of the word keep changing. This separates the six decoded classes from one another, and it catches any stray control bit that an undefined opcode might assert. It then sweeps all 64 funct values under R-type, under lw and under beq. Under R-type only the five listed codes may select a non-zero operation. Under lw and beq the funct field must have no effect. Immediates are stepped across the whole 16-bit range, including both sign boundaries. This exposes a wrong fill bit in the extension and a wrong shift in the branch target. Addresses are varied in their top nibble, so a jump that takes its region bits from the wrong place shows up.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OP_W     = 6;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned JIDX_W   = 26;
  localparam int unsigned ALUF_W   = 4;
  localparam int unsigned REGION_W = WORD_W - JIDX_W - 2;
  localparam logic [WORD_W-1:0] PC_STEP = WORD_W'(4);

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OP_W-1:0] OPC_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OPC_SW    = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_J     = 6'b000010;

  localparam logic [OP_W-1:0] FN_ADD = 6'b100000;
  localparam logic [OP_W-1:0] FN_SUB = 6'b100010;
  localparam logic [OP_W-1:0] FN_AND = 6'b100100;
  localparam logic [OP_W-1:0] FN_OR  = 6'b100101;
  localparam logic [OP_W-1:0] FN_SLT = 6'b101010;

  localparam logic [ALUF_W-1:0] ALU_AND = 4'b0000;
  localparam logic [ALUF_W-1:0] ALU_OR  = 4'b0001;
  localparam logic [ALUF_W-1:0] ALU_ADD = 4'b0010;
  localparam logic [ALUF_W-1:0] ALU_SUB = 4'b0110;
  localparam logic [ALUF_W-1:0] ALU_SLT = 4'b0111;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_class_e;

  typedef struct packed {
    logic       dst_rd;
    logic       jmp_en;
    logic       br_en;
    logic       mrd_en;
    logic       wb_mem;
    logic [1:0] alu_class;
    logic       mwr_en;
    logic       opb_imm;
    logic       rf_we;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] branch_dest(input logic [WORD_W-1:0] seq,
                                                    input logic [WORD_W-1:0] ext);
    return seq + {ext[WORD_W-3:0], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] jump_dest(input logic [WORD_W-1:0] seq,
                                                  input logic [JIDX_W-1:0] idx);
    return {seq[WORD_W-1 -: REGION_W], idx, 2'b00};
  endfunction

  function automatic logic [ALUF_W-1:0] funct_to_alu(input logic [OP_W-1:0] fn);
    logic [ALUF_W-1:0] r;
    case (fn)
      FN_ADD:  r = ALU_ADD;
      FN_SUB:  r = ALU_SUB;
      FN_AND:  r = ALU_AND;
      FN_OR:   r = ALU_OR;
      FN_SLT:  r = ALU_SLT;
      default: r = ALU_AND;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mdec_fields.sv
module mdec_fields
  import mdec_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output logic [OP_W-1:0]   opcode,
  output logic [REG_W-1:0]  rs,
  output logic [REG_W-1:0]  rt,
  output logic [REG_W-1:0]  rd,
  output logic [REG_W-1:0]  shamt,
  output logic [OP_W-1:0]   funct,
  output logic [IMM_W-1:0]  imm,
  output logic [JIDX_W-1:0] jidx
);

  localparam int unsigned RS_LSB = WORD_W - OP_W - REG_W;
  localparam int unsigned RT_LSB = RS_LSB - REG_W;
  localparam int unsigned RD_LSB = RT_LSB - REG_W;
  localparam int unsigned SH_LSB = RD_LSB - REG_W;

  assign opcode = instr[WORD_W-1 -: OP_W];
  assign rs     = instr[RS_LSB +: REG_W];
  assign rt     = instr[RT_LSB +: REG_W];
  assign rd     = instr[RD_LSB +: REG_W];
  assign shamt  = instr[SH_LSB +: REG_W];
  assign funct  = instr[OP_W-1:0];
  assign imm    = instr[IMM_W-1:0];
  assign jidx   = instr[JIDX_W-1:0];

endmodule

// File: rtl/mdec_main_ctrl.sv
module mdec_main_ctrl
  import mdec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrl_t           ctrl
);

  logic is_rtype, is_addi, is_lw, is_sw, is_beq, is_j, is_known;

  always_comb begin
    is_rtype = (opcode == OPC_RTYPE);
    is_addi  = (opcode == OPC_ADDI);
    is_lw    = (opcode == OPC_LW);
    is_sw    = (opcode == OPC_SW);
    is_beq   = (opcode == OPC_BEQ);
    is_j     = (opcode == OPC_J);
    is_known = is_rtype | is_addi | is_lw | is_sw | is_beq | is_j;

    ctrl = '0;
    if (is_rtype) begin
      ctrl.dst_rd    = 1'b1;
      ctrl.rf_we     = 1'b1;
      ctrl.alu_class = CLS_FUNCT;
    end
    if (is_addi) begin
      ctrl.opb_imm   = 1'b1;
      ctrl.rf_we     = 1'b1;
      ctrl.alu_class = CLS_ADD;
    end
    if (is_lw) begin
      ctrl.opb_imm   = 1'b1;
      ctrl.wb_mem    = 1'b1;
      ctrl.rf_we     = 1'b1;
      ctrl.mrd_en    = 1'b1;
      ctrl.alu_class = CLS_ADD;
    end
    if (is_sw) begin
      ctrl.opb_imm   = 1'b1;
      ctrl.mwr_en    = 1'b1;
      ctrl.alu_class = CLS_ADD;
    end
    if (is_beq) begin
      ctrl.br_en     = 1'b1;
      ctrl.alu_class = CLS_SUB;
    end
    if (is_j) begin
      ctrl.jmp_en    = 1'b1;
    end

    AST_UNKNOWN_QUIET: assert (is_known || ctrl == '0) else $error("unknown opcode asserted a control"); // R8
    AST_JUMP_ALONE: assert (!ctrl.jmp_en || (ctrl & ~ctrl_t'(10'b0100000000)) == '0) else $error("jump with other controls"); // R7
    AST_MEM_EXCL: assert (!(ctrl.mrd_en && ctrl.mwr_en)) else $error("read and write together"); // R4
    AST_WB_NEEDS_READ: assert (!ctrl.wb_mem || (ctrl.mrd_en && ctrl.rf_we)) else $error("memory write-back without read"); // R3
    AST_BRANCH_SUBTRACTS: assert (!ctrl.br_en || (ctrl.alu_class == CLS_SUB && !ctrl.rf_we)) else $error("branch class wrong"); // R5
    AST_RD_ONLY_RTYPE: assert (!ctrl.dst_rd || ctrl.alu_class == CLS_FUNCT) else $error("rd selected outside R-type"); // R2
    AST_IMM_FORMS_ADD: assert (!ctrl.opb_imm || ctrl.alu_class == CLS_ADD) else $error("immediate operand without add"); // R6
  end

endmodule

// File: rtl/mdec_alu_ctrl.sv
module mdec_alu_ctrl
  import mdec_pkg::*;
(
  input  logic [1:0]        alu_class,
  input  logic [OP_W-1:0]   funct,
  output logic [ALUF_W-1:0] alu_func
);

  logic class_fixed;

  always_comb begin
    class_fixed = (alu_class != CLS_FUNCT);
    case (alu_class)
      CLS_ADD:   alu_func = ALU_ADD;
      CLS_SUB:   alu_func = ALU_SUB;
      CLS_FUNCT: alu_func = funct_to_alu(funct);
      default:   alu_func = ALU_AND;
    endcase

    AST_ALU_CODE_LEGAL: assert (alu_func inside {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT}) else $error("illegal ALU code"); // R10
    AST_FIXED_IGNORES_FUNCT: assert (!class_fixed || alu_class == 2'b11 || alu_func[3:2] != 2'b00 || alu_func == ALU_ADD) else $error("fixed class followed funct"); // R9
  end

endmodule

// File: rtl/mdec_targets.sv
module mdec_targets
  import mdec_pkg::*;
(
  input  logic [WORD_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JIDX_W-1:0] jidx,
  output logic [WORD_W-1:0] imm_ext,
  output logic [WORD_W-1:0] pc_plus4,
  output logic [WORD_W-1:0] br_target,
  output logic [WORD_W-1:0] jmp_target
);

  logic [WORD_W-IMM_W-1:0] ext_fill;

  always_comb begin
    imm_ext    = sext_imm(imm);
    pc_plus4   = pc + PC_STEP;
    br_target  = branch_dest(pc_plus4, imm_ext);
    jmp_target = jump_dest(pc_plus4, jidx);
    ext_fill   = imm_ext[WORD_W-1:IMM_W];

    AST_SEXT_FILL: assert ((ext_fill == '0 || ext_fill == '1) && ext_fill[0] == imm[IMM_W-1] && imm_ext[IMM_W-1:0] == imm) else $error("bad sign extension"); // R11
    AST_BR_ALIGN: assert (br_target[1:0] == pc[1:0]) else $error("branch target misaligned"); // R12
    AST_JMP_REGION: assert (jmp_target[WORD_W-1 -: REGION_W] == pc_plus4[WORD_W-1 -: REGION_W] && jmp_target[1:0] == 2'b00) else $error("jump region wrong"); // R13
  end

endmodule

// File: rtl/mips_subset_decoder.sv
module mips_subset_decoder
  import mdec_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  output logic [5:0]  opcode,
  output logic [4:0]  rs,
  output logic [4:0]  rt,
  output logic [4:0]  rd,
  output logic [4:0]  shamt,
  output logic [5:0]  funct,
  output logic [15:0] imm,
  output logic [25:0] jidx,
  output logic        dst_rd,
  output logic        jmp_en,
  output logic        br_en,
  output logic        mrd_en,
  output logic        wb_mem,
  output logic [1:0]  alu_class,
  output logic        mwr_en,
  output logic        opb_imm,
  output logic        rf_we,
  output logic [3:0]  alu_func,
  output logic [31:0] imm_ext,
  output logic [31:0] pc_plus4,
  output logic [31:0] br_target,
  output logic [31:0] jmp_target
);

  ctrl_t ctrl;

  mdec_fields u_fields (
    .instr(instr), .opcode(opcode), .rs(rs), .rt(rt), .rd(rd),
    .shamt(shamt), .funct(funct), .imm(imm), .jidx(jidx)
  );

  mdec_main_ctrl u_main (
    .opcode(opcode), .ctrl(ctrl)
  );

  assign dst_rd    = ctrl.dst_rd;
  assign jmp_en    = ctrl.jmp_en;
  assign br_en     = ctrl.br_en;
  assign mrd_en    = ctrl.mrd_en;
  assign wb_mem    = ctrl.wb_mem;
  assign alu_class = ctrl.alu_class;
  assign mwr_en    = ctrl.mwr_en;
  assign opb_imm   = ctrl.opb_imm;
  assign rf_we     = ctrl.rf_we;

  mdec_alu_ctrl u_alu (
    .alu_class(ctrl.alu_class), .funct(funct), .alu_func(alu_func)
  );

  mdec_targets u_tgt (
    .pc(pc), .imm(imm), .jidx(jidx), .imm_ext(imm_ext),
    .pc_plus4(pc_plus4), .br_target(br_target), .jmp_target(jmp_target)
  );

endmodule

// File: tb/mips_subset_decoder_test.sv
module mips_subset_decoder_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, shamt;
  logic [15:0] imm;
  logic [25:0] jidx;
  logic        dst_rd, jmp_en, br_en, mrd_en, wb_mem, mwr_en, opb_imm, rf_we;
  logic [1:0]  alu_class;
  logic [3:0]  alu_func;
  logic [31:0] imm_ext, pc_plus4, br_target, jmp_target;

  int checks = 0;
  int errors = 0;

  mips_subset_decoder uut (
    .instr(instr), .pc(pc), .opcode(opcode), .rs(rs), .rt(rt), .rd(rd),
    .shamt(shamt), .funct(funct), .imm(imm), .jidx(jidx), .dst_rd(dst_rd),
    .jmp_en(jmp_en), .br_en(br_en), .mrd_en(mrd_en), .wb_mem(wb_mem),
    .alu_class(alu_class), .mwr_en(mwr_en), .opb_imm(opb_imm), .rf_we(rf_we),
    .alu_func(alu_func), .imm_ext(imm_ext), .pc_plus4(pc_plus4),
    .br_target(br_target), .jmp_target(jmp_target)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (instr %h pc %h)", req, act, exp, instr, pc);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a);
    @(negedge clk);
    instr = w;
    pc = a;
    #2;
  endtask

  // control vector order: dst_rd jmp br mrd wb_mem class[1:0] mwr opb_imm rf_we
  function automatic logic [9:0] exp_ctrl(input logic [5:0] op);
    case (op)
      6'b000000: return 10'b1_0_0_0_0_10_0_0_1; // R2
      6'b100011: return 10'b0_0_0_1_1_00_0_1_1; // R3
      6'b101011: return 10'b0_0_0_0_0_00_1_1_0; // R4
      6'b000100: return 10'b0_0_1_0_0_01_0_0_0; // R5
      6'b001000: return 10'b0_0_0_0_0_00_0_1_1; // R6
      6'b000010: return 10'b0_1_0_0_0_00_0_0_0; // R7
      default:   return 10'b0;                   // R8
    endcase
  endfunction

  function automatic string ctrl_tag(input logic [5:0] op);
    case (op)
      6'b000000: return "R2";
      6'b100011: return "R3";
      6'b101011: return "R4";
      6'b000100: return "R5";
      6'b001000: return "R6";
      6'b000010: return "R7";
      default:   return "R8";
    endcase
  endfunction

  function automatic logic [3:0] exp_rfunc(input logic [5:0] fn);
    if (fn == 6'd32) return 4'd2;
    if (fn == 6'd34) return 4'd6;
    if (fn == 6'd36) return 4'd0;
    if (fn == 6'd37) return 4'd1;
    if (fn == 6'd42) return 4'd7;
    return 4'd0;
  endfunction

  function automatic logic [31:0] exp_sext(input logic [15:0] v);
    int s;
    s = (v >= 16'h8000) ? int'(v) - 65536 : int'(v);
    return 32'(s);
  endfunction

  task automatic check_targets(input logic [31:0] w, input logic [31:0] a);
    logic [31:0] e;
    apply(w, a);
    e = exp_sext(w[15:0]);
    check("R11 imm_ext", imm_ext, e);
    check("R12 pc_plus4", pc_plus4, a + 32'd4);
    check("R12 br_target", br_target, a + 32'd4 + e * 32'd4);
    check("R13 jmp_target", jmp_target, ((a + 32'd4) & 32'hF000_0000) + {6'd0, w[25:0]} * 32'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // idle state: all-zero word is an R-type with an unknown funct
    apply(32'h0, 32'h0);
    check("R2 idle ctrl", {22'd0, dst_rd, jmp_en, br_en, mrd_en, wb_mem, alu_class, mwr_en, opb_imm, rf_we}, {22'd0, exp_ctrl(6'd0)});
    check("R10 idle alu_func", {28'd0, alu_func}, 32'd0);

    // R1: field extraction with several bit patterns
    for (int k = 0; k < 32; k++) begin
      logic [31:0] w;
      w = (32'h9E37_79B9 * (k + 1)) ^ (32'h1 << k);
      apply(w, 32'h0040_0000);
      check("R1 opcode", {26'd0, opcode}, w >> 26);
      check("R1 rs", {27'd0, rs}, (w >> 21) & 32'h1F);
      check("R1 rt", {27'd0, rt}, (w >> 16) & 32'h1F);
      check("R1 rd", {27'd0, rd}, (w >> 11) & 32'h1F);
      check("R1 shamt", {27'd0, shamt}, (w >> 6) & 32'h1F);
      check("R1 funct", {26'd0, funct}, w & 32'h3F);
      check("R1 imm", {16'd0, imm}, w & 32'hFFFF);
      check("R1 jidx", {6'd0, jidx}, w & 32'h03FF_FFFF);
    end

    // R2..R8: every opcode, two different low-bit fillers
    for (int op = 0; op < 64; op++) begin
      for (int f = 0; f < 2; f++) begin
        logic [31:0] w;
        w = {op[5:0], (f == 0) ? 26'h3FF_FFFF : 26'h12_3456};
        apply(w, 32'h0040_0000);
        check(ctrl_tag(op[5:0]), {22'd0, dst_rd, jmp_en, br_en, mrd_en, wb_mem, alu_class, mwr_en, opb_imm, rf_we}, {22'd0, exp_ctrl(op[5:0])});
      end
    end

    // R10 / R9: every funct under R-type, lw and beq
    for (int fn = 0; fn < 64; fn++) begin
      apply({6'b000000, 5'd3, 5'd4, 5'd5, 5'd0, fn[5:0]}, 32'h0040_0000);
      check("R10 rtype alu_func", {28'd0, alu_func}, {28'd0, exp_rfunc(fn[5:0])});
      apply({6'b100011, 5'd6, 5'd7, 10'd0, fn[5:0]}, 32'h0040_0000);
      check("R9 lw alu_func", {28'd0, alu_func}, 32'd2);
      apply({6'b000100, 5'd5, 5'd0, 10'd0, fn[5:0]}, 32'h0040_0000);
      check("R9 beq alu_func", {28'd0, alu_func}, 32'd6);
    end
    apply(32'h2002_fffe, 32'h0040_0008);
    check("R9 addi alu_func", {28'd0, alu_func}, 32'd2);
    apply(32'hacc8_0064, 32'h0040_0030);
    check("R9 sw alu_func", {28'd0, alu_func}, 32'd2);

    // R11..R13: worked examples
    apply(32'h2002_fffe, 32'h0040_0008);
    check("R11 example neg", imm_ext, 32'hffff_fffe);
    apply(32'h20c6_03e8, 32'h0040_0028);
    check("R11 example pos", imm_ext, 32'h0000_03e8);
    apply(32'h10a0_fff8, 32'h0040_001c);
    check("R12 example", br_target, 32'h0040_0000);
    apply(32'h1000_0005, 32'h0040_0020);
    check("R12 example fwd", br_target, 32'h0040_0038);
    apply(32'h0810_0009, 32'h0040_0038);
    check("R13 example", jmp_target, 32'h0040_0024);
    apply(32'h0810_000f, 32'h0040_0034);
    check("R13 example fwd", jmp_target, 32'h0040_003c);

    // R11..R13: immediate sweep with varying region nibble and wrap
    for (int s = 0; s < 260; s++) begin
      logic [31:0] a;
      logic [31:0] w;
      a = {s[3:0], 28'h040_0000} + {s[9:0], 2'b00};
      w = {6'b000100, 10'h0A5, 16'(s * 253)};
      check_targets(w, a);
    end
    check_targets(32'h1000_7fff, 32'h0040_0000);
    check_targets(32'h1000_8000, 32'h0040_0000);
    check_targets(32'h1000_0000, 32'hffff_fffc);
    check_targets(32'h0bff_ffff, 32'hefff_fffc);
    check_targets(32'h0800_0000, 32'h7fff_fff8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule